// File: doc/BRIEF.md
# OQPSK chip stream merger

This block sits after the hard-decision slicers of an offset-QPSK receiver. The in-phase branch carries the even chips of the spread sequence and the quadrature branch carries the odd chips. The quadrature branch arrives one chip period after its in-phase partner. The block pairs each in-phase chip with the quadrature chip that follows it and puts both out as a single serial stream in transmit order: even chip first, then odd chip. The clock runs at the merged chip rate, which is 2 Mchip/s in the target system (32 chips per data symbol). Each branch therefore strobes at most once every two cycles.

A frame-start strobe arms the block and starts a new chip count. Once the frame has delivered its full chip count (704 chips by default, 352 per branch), the block pulses a done flag and ignores both branches until the next frame start. An in-phase chip is kept in a holding register until its quadrature partner arrives, so the gap between the two strobes can be of any length. Accepted quadrature strobes must be at least two cycles apart, which gives each merged pair the two output slots it needs.

Top module: `oqpsk_chip_merge`

## Requirements
- R1: Synchronous active-low reset. Under reset, chip_out, chip_valid and frame_done are 0. Reset also discards any held in-phase chip, clears the chip count and disarms the block, so strobes after reset produce nothing until a frame start.
- R2: Each accepted pair is output in this order: the in-phase chip on chip_out with chip_valid high, then the quadrature chip in the next cycle, bit for bit.
- R3: The in-phase chip appears on the outputs one cycle after the clock edge that samples the quadrature strobe. The quadrature chip appears one cycle after that.
- R4: A held in-phase chip waits any number of idle cycles for its quadrature strobe. No chip is lost and no chip is repeated.
- R5: A second in-phase strobe that comes before any quadrature strobe replaces the held chip. The pair is output with the newer in-phase chip.
- R6: A quadrature strobe with no held in-phase chip is ignored and produces no output.
- R7: frame_done is high for exactly one cycle, in the cycle after the last chip of the frame (chip FRAME_CHIPS) was valid on the outputs.
- R8: After FRAME_CHIPS/2 pairs have been accepted, and before the first frame start after reset, both branch strobes are ignored.
- R9: frame_start restarts the frame. It drops a held in-phase chip and any chip still to be output, and resets the count. An in-phase strobe in the same cycle is taken as chip 0 of the new frame. A quadrature strobe in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the merged chip rate |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe that begins a frame |
| i_stb | input | 1 | In-phase chip strobe |
| i_chip | input | 1 | In-phase hard-decision chip |
| q_stb | input | 1 | Quadrature chip strobe |
| q_chip | input | 1 | Quadrature hard-decision chip |
| chip_out | output | 1 | Merged serial chip |
| chip_valid | output | 1 | chip_out carries a chip this cycle |
| frame_done | output | 1 | One-cycle pulse after the last chip of a frame |

## Verification
The bench attacks the pairing at its edges. It uses back-to-back pairs with no gap and pairs with idle cycles between and after the strobes. A design without the holding register would drop or misplace in-phase chips when gaps are present. A design that emitted in strobe order rather than pair order would interleave wrongly. Stray quadrature strobes and doubled in-phase strobes catch a design that outputs orphans or keeps a stale chip. Strobes sent after the frame completes, and around a mid-frame restart or reset, expose a count that is off by one pair, a done pulse at the wrong cycle, or a held chip that leaks into the next frame.

// File: rtl/oqpsk_merge_pkg.sv
// Shared types and helpers for the OQPSK chip merger.
package oqpsk_merge_pkg;

    // One in-phase / quadrature chip pair, in output order.
    typedef struct packed {
        logic i_bit;
        logic q_bit;
    } chip_pair_t;

    // Counter width able to hold values 0 .. n-1.
    function automatic int unsigned cnt_w(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/oqpsk_pair_hold.sv
// Pairs an in-phase chip with the quadrature chip that follows it.
// Assumes: the armed input comes from the frame counter. Accepted q strobes
// are at least two cycles apart, which the output stage relies on.
module oqpsk_pair_hold
    import oqpsk_merge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       armed,
    input  logic       i_stb,
    input  logic       i_chip,
    input  logic       q_stb,
    input  logic       q_chip,
    output logic       pair_take,
    output chip_pair_t pair
);

    logic hold_bit;
    logic hold_vld;
    logic take_i;

    // Accept an I chip while armed, or as chip 0 in a frame-start cycle.
    assign take_i    = i_stb && (armed || frame_start);
    // A Q chip completes a pair only if an I chip is waiting.
    assign pair_take = q_stb && armed && hold_vld && !frame_start;
    assign pair      = '{i_bit: hold_bit, q_bit: q_chip};

    // Holding register: keep the newest unpaired I chip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_bit <= 1'b0;
            hold_vld <= 1'b0;
        end else if (frame_start) begin
            hold_bit <= i_chip;
            hold_vld <= i_stb;
        end else if (take_i) begin
            hold_bit <= i_chip;
            hold_vld <= 1'b1;
        end else if (pair_take) begin
            hold_vld <= 1'b0;
        end
    end

    AST_HOLD_CLEARS_ON_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_take && !i_stb) |=> !hold_vld); // R4

    AST_HOLD_LOADS_ON_I: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !frame_start) |=> (hold_vld && hold_bit == $past(i_chip))); // R5

endmodule

// File: rtl/oqpsk_frame_ctr.sv
// Frame bookkeeping: arms on frame_start, counts accepted pairs to disarm,
// and counts output chips to place the done pulse.
// Assumes FRAME_CHIPS is even and at least 2.
module oqpsk_frame_ctr
    import oqpsk_merge_pkg::*;
#(
    parameter int unsigned FRAME_CHIPS = 704
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic pair_take,
    input  logic chip_valid,
    output logic armed,
    output logic frame_done
);

    localparam int unsigned PAIRS = FRAME_CHIPS / 2;
    localparam int unsigned PW    = cnt_w(PAIRS);
    localparam int unsigned CW    = cnt_w(FRAME_CHIPS);

    logic [PW-1:0] pair_cnt;
    logic [CW-1:0] chip_cnt;
    logic          last_pair;
    logic          last_chip;

    assign last_pair = pair_take  && (pair_cnt == PW'(PAIRS - 1));
    assign last_chip = chip_valid && (chip_cnt == CW'(FRAME_CHIPS - 1));

    // Input side: arm on frame start, disarm after the final pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            pair_cnt <= '0;
        end else if (frame_start) begin
            armed    <= 1'b1;
            pair_cnt <= '0;
        end else if (pair_take) begin
            if (last_pair) begin
                armed    <= 1'b0;
                pair_cnt <= '0;
            end else begin
                pair_cnt <= pair_cnt + 1'b1;
            end
        end
    end

    // Output side: count valid chips, pulse done after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_cnt   <= '0;
            frame_done <= 1'b0;
        end else if (frame_start) begin
            chip_cnt   <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= last_chip;
            if (chip_valid) begin
                chip_cnt <= last_chip ? '0 : chip_cnt + 1'b1;
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R7

    AST_DONE_AFTER_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(chip_valid)); // R7

    AST_DISARM_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pair && !frame_start) |=> !armed); // R8

endmodule

// File: rtl/oqpsk_chip_emit.sv
// Output serializer: puts out the I chip of a pair, then its Q chip one
// cycle later, from a one-entry Q slot.
// Assumes a new pair never arrives while the Q slot is still occupied.
module oqpsk_chip_emit
    import oqpsk_merge_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       pair_take,
    input  chip_pair_t pair,
    output logic       chip_out,
    output logic       chip_valid
);

    logic out_bit;
    logic out_vld;
    logic q_slot;
    logic q_pend;

    // Drive the serial output: I on pair acceptance, then the queued Q.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_bit <= 1'b0;
            out_vld <= 1'b0;
            q_slot  <= 1'b0;
            q_pend  <= 1'b0;
        end else if (frame_start) begin
            out_vld <= 1'b0;
            q_pend  <= 1'b0;
        end else if (pair_take) begin
            out_bit <= pair.i_bit;
            out_vld <= 1'b1;
            q_slot  <= pair.q_bit;
            q_pend  <= 1'b1;
        end else if (q_pend) begin
            out_bit <= q_slot;
            out_vld <= 1'b1;
            q_pend  <= 1'b0;
        end else begin
            out_vld <= 1'b0;
        end
    end

    assign chip_out   = out_bit;
    assign chip_valid = out_vld;

    AST_NO_SLOT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        pair_take |-> !q_pend); // R2

    AST_Q_FOLLOWS_I: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pend && !frame_start) |=> (out_vld && out_bit == $past(q_slot))); // R2

    AST_SLOT_ONLY_AFTER_I: assert property (@(posedge clk) disable iff (!rst_n)
        q_pend |-> out_vld); // R3

endmodule

// File: rtl/oqpsk_chip_merge.sv
// Top of the OQPSK chip merger: pairing stage, frame counter and
// serializer. Clock runs at the merged chip rate.
module oqpsk_chip_merge
    import oqpsk_merge_pkg::*;
#(
    parameter int unsigned FRAME_CHIPS = 704
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic i_stb,
    input  logic i_chip,
    input  logic q_stb,
    input  logic q_chip,
    output logic chip_out,
    output logic chip_valid,
    output logic frame_done
);

    logic       armed;
    logic       pair_take;
    chip_pair_t pair;

    oqpsk_pair_hold u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .armed       (armed),
        .i_stb       (i_stb),
        .i_chip      (i_chip),
        .q_stb       (q_stb),
        .q_chip      (q_chip),
        .pair_take   (pair_take),
        .pair        (pair)
    );

    oqpsk_frame_ctr #(
        .FRAME_CHIPS (FRAME_CHIPS)
    ) u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pair_take   (pair_take),
        .chip_valid  (chip_valid),
        .armed       (armed),
        .frame_done  (frame_done)
    );

    oqpsk_chip_emit u_emit (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pair_take   (pair_take),
        .pair        (pair),
        .chip_out    (chip_out),
        .chip_valid  (chip_valid)
    );

    AST_ACCEPT_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        pair_take |-> armed); // R8

endmodule

// File: tb/sim_oqpsk_chip_merge.sv
// Scoreboard bench: driver tasks model the requirements and queue the
// expected chips; a monitor pops and compares each valid output chip.
module sim_oqpsk_chip_merge;

    localparam int unsigned FRAME = 704;
    localparam int unsigned PAIRS = FRAME / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic i_stb = 1'b0, i_chip = 1'b0, q_stb = 1'b0, q_chip = 1'b0;
    logic chip_out, chip_valid, frame_done;

    int checks = 0;
    int bad = 0;
    int spurious = 0;
    int done_seen = 0;
    int mon_count = 0;
    bit done_due = 0;
    string cur_req = "R1";
    bit exp_q[$];

    // Requirement model state.
    bit m_armed = 0, m_hold = 0, m_pend = 0;
    int m_pairs = 0;
    logic [15:0] lf = 16'hACE1;

    always #10 clk = ~clk;

    oqpsk_chip_merge #(.FRAME_CHIPS(FRAME)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .i_stb(i_stb), .i_chip(i_chip), .q_stb(q_stb), .q_chip(q_chip),
        .chip_out(chip_out), .chip_valid(chip_valid), .frame_done(frame_done)
    );

    function automatic bit rnd();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[0];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply one cycle of stimulus to the requirement model.
    task automatic model_step(input bit fs, input bit is, input bit ib, input bit qs, input bit qb);
        bit armed0;
        armed0 = m_armed;
        if (!rst_n) begin
            m_armed = 0; m_pend = 0; m_pairs = 0; mon_count = 0;
        end else if (fs) begin
            m_armed = 1; m_pairs = 0; m_pend = is; m_hold = ib; mon_count = 0;
        end else begin
            if (qs && armed0 && m_pend) begin
                exp_q.push_back(m_hold);
                exp_q.push_back(qb);
                m_pend = 0;
                m_pairs++;
                if (m_pairs == PAIRS) m_armed = 0;
            end
            if (is && armed0) begin
                m_pend = 1; m_hold = ib;
            end
        end
    endtask

    task automatic cyc(input bit fs, input bit is, input bit ib, input bit qs, input bit qb);
        @(negedge clk);
        frame_start = fs; i_stb = is; i_chip = ib; q_stb = qs; q_chip = qb;
        model_step(fs, is, ib, qs, qb);
    endtask

    task automatic idle(input int n);
        repeat (n) cyc(0, 0, 0, 0, 0);
    endtask

    task automatic send_pair(input bit ib, input bit qb, input int gap_iq, input int gap_after);
        cyc(0, 1, ib, 0, 0);
        idle(gap_iq);
        cyc(0, 0, 0, 1, qb);
        idle(gap_after);
    endtask

    task automatic do_reset(input int n);
        repeat (n) begin
            @(negedge clk);
            rst_n = 1'b0;
            frame_start = 0; i_stb = 0; q_stb = 0;
            model_step(0, 0, 0, 0, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        model_step(0, 0, 0, 0, 0);
    endtask

    task automatic drain();
        idle(4);
        while (exp_q.size() != 0) idle(1);
        idle(3);
    endtask

    // Monitor: compare each valid chip and police the done pulse.
    initial begin
        forever begin
            @(negedge clk);
            if (frame_done === 1'b1) begin
                done_seen++;
                check(done_due, "R7", 1, done_due);
                done_due = 0;
            end else if (done_due) begin
                check(0, "R7", 0, 1);
                done_due = 0;
            end
            if (chip_valid === 1'b1) begin
                if (exp_q.size() == 0) begin
                    spurious++;
                    check(0, cur_req, 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(chip_out === e, cur_req, int'(chip_out), int'(e));
                    mon_count++;
                    if (mon_count == FRAME) begin
                        done_due = 1;
                        mon_count = 0;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        int sp0;
        int dn0;
        bit b;
        // R1: reset state
        do_reset(3);
        check(chip_valid === 1'b0, "R1", int'(chip_valid), 0);
        check(chip_out === 1'b0, "R1", int'(chip_out), 0);
        check(frame_done === 1'b0, "R1", int'(frame_done), 0);

        // R8: strobes before any frame start are ignored
        cur_req = "R8";
        sp0 = spurious;
        for (int k = 0; k < 6; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        check(spurious == sp0, "R8", spurious - sp0, 0);

        // R3: latency of a pair, as frame 1 begins
        cur_req = "R3";
        cyc(1, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        check(chip_valid === 1'b1 && chip_out === 1'b1, "R3", int'({chip_valid, chip_out}), 3);
        cyc(0, 0, 0, 0, 0);
        check(chip_valid === 1'b1 && chip_out === 1'b0, "R3", int'({chip_valid, chip_out}), 2);

        // R2: rest of frame 1, back-to-back pairs
        cur_req = "R2";
        dn0 = done_seen;
        for (int k = 1; k < PAIRS; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        check(done_seen == dn0 + 1, "R7", done_seen - dn0, 1);

        // R8: strobes after the frame completed are ignored
        cur_req = "R8";
        sp0 = spurious;
        for (int k = 0; k < 10; k++) send_pair(rnd(), rnd(), 0, 1);
        drain();
        check(spurious == sp0, "R8", spurious - sp0, 0);

        // R4: frame 2 with gaps between and after strobes
        cur_req = "R4";
        dn0 = done_seen;
        cyc(1, 1, rnd(), 0, 0);
        idle(2);
        cyc(0, 0, 0, 1, rnd());
        idle(1);
        for (int k = 1; k < PAIRS; k++) begin
            int g1, g2;
            g1 = int'(lf[1:0]);
            g2 = int'(lf[3:2]) % 3;
            b = rnd();
            send_pair(b, rnd(), g1, g2);
        end
        drain();
        check(done_seen == dn0 + 1, "R4", done_seen - dn0, 1);
        check(exp_q.size() == 0, "R4", exp_q.size(), 0);

        // R5: newer I replaces a held one
        cur_req = "R5";
        cyc(1, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 0);
        cyc(0, 0, 0, 0, 0);
        check(chip_valid === 1'b1 && chip_out === 1'b1, "R5", int'({chip_valid, chip_out}), 3);
        cyc(0, 0, 0, 0, 0);
        check(chip_valid === 1'b1 && chip_out === 1'b0, "R5", int'({chip_valid, chip_out}), 2);

        // R6: lone Q strobe makes no output
        cur_req = "R6";
        sp0 = spurious;
        idle(2);
        cyc(0, 0, 0, 1, 1);
        idle(4);
        check(spurious == sp0, "R6", spurious - sp0, 0);

        // R9: restart mid-frame with a held I and a Q in the start cycle
        cur_req = "R9";
        for (int k = 0; k < 100; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        dn0 = done_seen;
        check(dn0 == done_seen, "R9", done_seen, dn0);
        cyc(0, 1, 1, 0, 0);
        cyc(1, 1, 0, 1, 1);
        cyc(0, 0, 0, 1, 1);
        for (int k = 1; k < PAIRS; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        check(done_seen == dn0 + 1, "R9", done_seen - dn0, 1);

        // R1: reset mid-frame drops held I and disarms
        cur_req = "R1";
        cyc(1, 1, 0, 0, 0);
        cyc(0, 0, 0, 1, 1);
        for (int k = 0; k < 4; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        cyc(0, 1, 1, 0, 0);
        do_reset(2);
        sp0 = spurious;
        cyc(0, 0, 0, 1, 0);
        for (int k = 0; k < 4; k++) send_pair(rnd(), rnd(), 0, 0);
        drain();
        check(spurious == sp0, "R1", spurious - sp0, 0);
        check(exp_q.size() == 0, "R1", exp_q.size(), 0);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule